// File: doc/BRIEF.md
# Virtual Message Queue Translation Cache

This block sits in front of the hardware message-queue engine of a network interface. Software sends messages through virtual transmit queue names; the block looks that name up in a small pool of hardware-resident transmit queue slots. On a hit it checks that the sending protection domain owns the queue and that the destination of this particular message is inside the range of receive queues the transmit queue may reach. It then answers on the response port with either a grant carrying the resident slot number or a protection error. On a miss the request is handed unchanged to a firmware service port, where an emulated queue with the same interface handles it. A miss is never an error.

A second, independent pool of resident receive queue slots is searched with the destination name of each send. The response says whether the destination is resident locally and in which slot. A management port installs, replaces, rebinds and evicts entries in either pool. Each displaced or evicted name is reported on an eviction port so that firmware can write the queue state back to memory. The resident pools therefore behave as a firmware-managed cache over a much larger name space.

Top module: `vq_xlate`

## Requirements
- R1: After reset both pools are empty: no response, divert or eviction is pending, `req_ready` is 1, and every send request is diverted.
- R2: A send whose name matches a valid transmit entry, whose domain equals the entry's domain and whose destination lies in the entry's inclusive range [lo, hi] gives `rsp_valid`=1, `rsp_err`=0 and `rsp_slot` = the entry's slot, one cycle after acceptance, with no divert.
- R3: A send whose name matches no valid transmit entry raises `div_valid` one cycle after acceptance with the same name, domain and destination, and gives no response.
- R4: While `div_valid`=1 and `div_ready`=0, the divert payload holds stable, `req_ready` is 0, and no request is accepted or lost; a held request is accepted on the edge where the divert is taken.
- R5: A hit whose request domain differs from the entry's domain gives `rsp_valid`=1 with `rsp_err`=1.
- R6: The range check is made per message: the same queue grants for destinations at lo and hi and refuses (`rsp_err`=1) for a destination just outside the range.
- R7: An install (`mgmt_op`=0) of a name that is already valid in the selected pool overwrites that entry in its existing slot, whatever `mgmt_slot` says, and reports no eviction.
- R8: An evict (`mgmt_op`=1) clears the slot named by `mgmt_slot`; if it was valid, `ev_valid`=1 with its name on `ev_vq` and the pool on `ev_pool` (0 transmit, 1 receive) one cycle later.
- R9: An install of a new name into an occupied slot reports the displaced name on the eviction port one cycle later.
- R10: When a management write and a send arrive in the same cycle, the send is resolved against the mapping before the write; the write is seen from the next cycle.
- R11: `mgmt_pool`=1 acts only on the receive pool; a send reports `rsp_dst_local`=1 and `rsp_dst_slot` when its destination name is resident there, and transmit lookups are unaffected by receive-pool writes.
- R12: After a name is rebound or evicted, later sends for it follow the new mapping (new slot, or divert).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Send request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_vq | input | 12 | Virtual transmit queue name |
| req_dom | input | 4 | Sender protection domain |
| req_dst | input | 12 | Destination virtual receive queue of this message |
| rsp_valid | output | 1 | Fast-path response present |
| rsp_err | output | 1 | 1 = protection error, 0 = grant |
| rsp_slot | output | 4 | Resident transmit slot |
| rsp_dst_local | output | 1 | Destination resident in the receive pool |
| rsp_dst_slot | output | 4 | Receive slot of the destination |
| div_valid | output | 1 | Request diverted to firmware |
| div_ready | input | 1 | Firmware takes the divert |
| div_vq | output | 12 | Diverted queue name |
| div_dom | output | 4 | Diverted domain |
| div_dst | output | 12 | Diverted destination |
| mgmt_valid | input | 1 | Management command present |
| mgmt_pool | input | 1 | 0 transmit pool, 1 receive pool |
| mgmt_op | input | 1 | 0 install, 1 evict |
| mgmt_slot | input | 4 | Target slot |
| mgmt_vq | input | 12 | Name to install |
| mgmt_dom | input | 4 | Owner domain to install |
| mgmt_lo | input | 12 | Lowest reachable destination |
| mgmt_hi | input | 12 | Highest reachable destination |
| ev_valid | output | 1 | Entry displaced or evicted |
| ev_pool | output | 1 | Pool of the evicted entry |
| ev_vq | output | 12 | Name of the evicted entry |

## Verification
Responses, diverts and eviction reports are all registered once, so each is due on the first rising edge after the request or command is taken. The bench drives inputs on the falling edge, removes them on the next falling edge and samples there, half a cycle after that due edge. Expected values come from a bench model of both pools that is updated only after the comparison, so a command and a send in the same cycle are checked against the old mapping. During a divert stall the payload and `req_ready` are sampled on several consecutive falling edges, and the held request is expected on the edge where `div_ready` rises.

// File: rtl/vqx_pkg.sv
package vqx_pkg;
    localparam int VQ_W  = 12;
    localparam int DOM_W = 4;

    typedef enum logic {
        OP_INSTALL = 1'b0,
        OP_EVICT   = 1'b1
    } mop_e;

    typedef struct packed {
        logic [VQ_W-1:0]  vq;
        logic [DOM_W-1:0] dom;
        logic [VQ_W-1:0]  lo;
        logic [VQ_W-1:0]  hi;
    } ent_t;

    function automatic logic reach_ok(input ent_t e, input logic [VQ_W-1:0] dst);
        return (dst >= e.lo) && (dst <= e.hi);
    endfunction
endpackage

// File: rtl/vqx_cam.sv
module vqx_cam
    import vqx_pkg::*;
#(
    parameter int N = 16,
    localparam int SW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [VQ_W-1:0] lk_vq,
    output logic            lk_hit,
    output logic [SW-1:0]   lk_slot,
    output ent_t            lk_ent,
    input  logic            wr_en,
    input  mop_e            wr_op,
    input  logic [SW-1:0]   wr_slot,
    input  ent_t            wr_ent,
    output logic            ev_valid,
    output logic [VQ_W-1:0] ev_vq
);
    logic [N-1:0] vld;
    ent_t         tab [N];
    logic [N-1:0] lk_m, wr_m;
    logic         wr_hit;
    logic [SW-1:0] wr_hslot, tgt;

    for (genvar i = 0; i < N; i++) begin : g_match
        assign lk_m[i] = vld[i] && (tab[i].vq == lk_vq);
        assign wr_m[i] = vld[i] && (tab[i].vq == wr_ent.vq);
    end

    always_comb begin
        lk_slot  = '0;
        wr_hslot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lk_m[i]) lk_slot = SW'(i);
            if (wr_m[i]) wr_hslot = SW'(i);
        end
        lk_hit = |lk_m;
        wr_hit = |wr_m;
        lk_ent = tab[lk_slot];
        tgt    = wr_hit ? wr_hslot : wr_slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld      <= '0;
            ev_valid <= 1'b0;
            ev_vq    <= '0;
        end else begin
            ev_valid <= 1'b0;
            if (wr_en) begin
                if (wr_op == OP_INSTALL) begin
                    tab[tgt] <= wr_ent;
                    vld[tgt] <= 1'b1;
                    if (vld[tgt] && tab[tgt].vq != wr_ent.vq) begin
                        ev_valid <= 1'b1;
                        ev_vq    <= tab[tgt].vq;
                    end
                end else begin
                    vld[wr_slot] <= 1'b0;
                    if (vld[wr_slot]) begin
                        ev_valid <= 1'b1;
                        ev_vq    <= tab[wr_slot].vq;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vqx_guard.sv
module vqx_guard
    import vqx_pkg::*;
(
    input  ent_t             ent,
    input  logic [DOM_W-1:0] dom,
    input  logic [VQ_W-1:0]  dst,
    output logic             pass
);
    logic dom_ok;
    assign dom_ok = (ent.dom == dom);
    assign pass   = dom_ok && reach_ok(ent, dst);
endmodule

// File: rtl/vq_xlate.sv
module vq_xlate
    import vqx_pkg::*;
#(
    parameter int N_TX = 16,
    parameter int N_RX = 16,
    localparam int TX_SW = $clog2(N_TX),
    localparam int RX_SW = $clog2(N_RX),
    localparam int MS_W  = (TX_SW > RX_SW) ? TX_SW : RX_SW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VQ_W-1:0]  req_vq,
    input  logic [DOM_W-1:0] req_dom,
    input  logic [VQ_W-1:0]  req_dst,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [TX_SW-1:0] rsp_slot,
    output logic             rsp_dst_local,
    output logic [RX_SW-1:0] rsp_dst_slot,
    output logic             div_valid,
    input  logic             div_ready,
    output logic [VQ_W-1:0]  div_vq,
    output logic [DOM_W-1:0] div_dom,
    output logic [VQ_W-1:0]  div_dst,
    input  logic             mgmt_valid,
    input  logic             mgmt_pool,
    input  logic             mgmt_op,
    input  logic [MS_W-1:0]  mgmt_slot,
    input  logic [VQ_W-1:0]  mgmt_vq,
    input  logic [DOM_W-1:0] mgmt_dom,
    input  logic [VQ_W-1:0]  mgmt_lo,
    input  logic [VQ_W-1:0]  mgmt_hi,
    output logic             ev_valid,
    output logic             ev_pool,
    output logic [VQ_W-1:0]  ev_vq
);
    ent_t             wr_ent, tx_ent, rx_ent;
    logic             tx_hit, rx_hit, pass, accept;
    logic [TX_SW-1:0] tx_slot;
    logic [RX_SW-1:0] rx_slot;
    logic             tx_ev, rx_ev;
    logic [VQ_W-1:0]  tx_evq, rx_evq;

    assign wr_ent = '{vq: mgmt_vq, dom: mgmt_dom, lo: mgmt_lo, hi: mgmt_hi};

    vqx_cam #(.N(N_TX)) u_tx (
        .clk(clk), .rst(rst),
        .lk_vq(req_vq), .lk_hit(tx_hit), .lk_slot(tx_slot), .lk_ent(tx_ent),
        .wr_en(mgmt_valid && !mgmt_pool), .wr_op(mop_e'(mgmt_op)),
        .wr_slot(mgmt_slot[TX_SW-1:0]), .wr_ent(wr_ent),
        .ev_valid(tx_ev), .ev_vq(tx_evq)
    );

    vqx_cam #(.N(N_RX)) u_rx (
        .clk(clk), .rst(rst),
        .lk_vq(req_dst), .lk_hit(rx_hit), .lk_slot(rx_slot), .lk_ent(rx_ent),
        .wr_en(mgmt_valid && mgmt_pool), .wr_op(mop_e'(mgmt_op)),
        .wr_slot(mgmt_slot[RX_SW-1:0]), .wr_ent(wr_ent),
        .ev_valid(rx_ev), .ev_vq(rx_evq)
    );

    vqx_guard u_guard (
        .ent(tx_ent), .dom(req_dom), .dst(req_dst), .pass(pass)
    );

    assign req_ready = !div_valid || div_ready;
    assign accept    = req_valid && req_ready;
    assign ev_valid  = tx_ev || rx_ev;
    assign ev_pool   = rx_ev;
    assign ev_vq     = tx_ev ? tx_evq : rx_evq;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_err       <= 1'b0;
            rsp_slot      <= '0;
            rsp_dst_local <= 1'b0;
            rsp_dst_slot  <= '0;
            div_valid     <= 1'b0;
            div_vq        <= '0;
            div_dom       <= '0;
            div_dst       <= '0;
        end else begin
            rsp_valid <= accept && tx_hit;
            if (accept && tx_hit) begin
                rsp_err       <= !pass;
                rsp_slot      <= tx_slot;
                rsp_dst_local <= rx_hit;
                rsp_dst_slot  <= rx_slot;
            end
            if (accept && !tx_hit) begin
                div_valid <= 1'b1;
                div_vq    <= req_vq;
                div_dom   <= req_dom;
                div_dst   <= req_dst;
            end else if (div_ready) begin
                div_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vq_xlate_chk.sv
module vq_xlate_chk
    import vqx_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            div_valid,
    input logic            div_ready,
    input logic [VQ_W-1:0] div_vq,
    input logic [VQ_W-1:0] div_dst,
    input logic            mgmt_valid,
    input logic            ev_valid
);
    // R2: a response only follows an accepted request
    p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready));

    // R3: a fast-path response never coexists with a pending divert
    p_hit_not_diverted_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !div_valid);

    // R4: stalled divert keeps its payload
    p_div_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (div_valid && !div_ready) |=> (div_valid && $stable(div_vq) && $stable(div_dst)));

    // R4: a refused request yields no response
    p_no_rsp_when_held_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> !rsp_valid);

    // R8: evictions only follow a management command
    p_ev_cause_r8: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> $past(mgmt_valid));
endmodule

bind vq_xlate vq_xlate_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .div_valid(div_valid), .div_ready(div_ready),
    .div_vq(div_vq), .div_dst(div_dst), .mgmt_valid(mgmt_valid), .ev_valid(ev_valid)
);

// File: tb/vq_xlate_bench.sv
module vq_xlate_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic req_valid = 0, div_ready = 1, mgmt_valid = 0, mgmt_pool = 0, mgmt_op = 0;
    logic [11:0] req_vq = 0, req_dst = 0, mgmt_vq = 0, mgmt_lo = 0, mgmt_hi = 0;
    logic [3:0]  req_dom = 0, mgmt_dom = 0, mgmt_slot = 0;
    logic req_ready, rsp_valid, rsp_err, rsp_dst_local, div_valid, ev_valid, ev_pool;
    logic [3:0] rsp_slot, rsp_dst_slot, div_dom;
    logic [11:0] div_vq, div_dst, ev_vq;

    vq_xlate u_vq_xlate (.*);

    int nchk = 0, nerr = 0;
    bit tv[16], rv[16];
    int tq[16], td[16], tl[16], th[16], rq[16];

    task automatic ck(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int find_tx(int vq);
        for (int i = 0; i < 16; i++) if (tv[i] && tq[i] == vq) return i;
        return -1;
    endfunction
    function automatic int find_rx(int vq);
        for (int i = 0; i < 16; i++) if (rv[i] && rq[i] == vq) return i;
        return -1;
    endfunction

    // expected outcome of a send against the current model
    int e_hit, e_err, e_slot, e_loc, e_dslot;
    task automatic predict(int vq, int dom, int dst);
        e_slot = find_tx(vq);
        e_hit = (e_slot >= 0);
        e_err = 0;
        if (e_hit) e_err = !(td[e_slot] == dom && dst >= tl[e_slot] && dst <= th[e_slot]);
        e_dslot = find_rx(dst);
        e_loc = (e_dslot >= 0);
    endtask

    task automatic check_send(string tag, int vq, int dom, int dst);
        ck({tag, " rsp_valid"}, rsp_valid, e_hit);
        ck({tag, " div_valid"}, div_valid, !e_hit);
        if (e_hit) begin
            ck({tag, " rsp_err"}, rsp_err, e_err);
            ck({tag, " rsp_slot"}, rsp_slot, e_slot);
            ck({tag, " dst_local"}, rsp_dst_local, e_loc);
            if (e_loc) ck({tag, " dst_slot"}, rsp_dst_slot, e_dslot);
        end else begin
            ck({tag, " div_vq"}, div_vq, vq);
            ck({tag, " div_dom"}, div_dom, dom);
            ck({tag, " div_dst"}, div_dst, dst);
        end
    endtask

    int x_ev, x_evq;
    task automatic model_apply(int pool, int op, int slot, int vq, int dom, int lo, int hi);
        int t;
        x_ev = 0; x_evq = 0;
        if (pool == 0) begin
            if (op == 0) begin
                t = find_tx(vq); if (t < 0) t = slot;
                if (tv[t] && tq[t] != vq) begin x_ev = 1; x_evq = tq[t]; end
                tv[t] = 1; tq[t] = vq; td[t] = dom; tl[t] = lo; th[t] = hi;
            end else begin
                if (tv[slot]) begin x_ev = 1; x_evq = tq[slot]; end
                tv[slot] = 0;
            end
        end else begin
            if (op == 0) begin
                t = find_rx(vq); if (t < 0) t = slot;
                if (rv[t] && rq[t] != vq) begin x_ev = 1; x_evq = rq[t]; end
                rv[t] = 1; rq[t] = vq;
            end else begin
                if (rv[slot]) begin x_ev = 1; x_evq = rq[slot]; end
                rv[slot] = 0;
            end
        end
    endtask

    task automatic drive_mgmt(int pool, int op, int slot, int vq, int dom, int lo, int hi);
        mgmt_valid = 1; mgmt_pool = pool[0]; mgmt_op = op[0]; mgmt_slot = slot[3:0];
        mgmt_vq = vq[11:0]; mgmt_dom = dom[3:0]; mgmt_lo = lo[11:0]; mgmt_hi = hi[11:0];
    endtask

    task automatic check_ev(string tag, int pool);
        ck({tag, " ev_valid"}, ev_valid, x_ev);
        if (x_ev) begin
            ck({tag, " ev_vq"}, ev_vq, x_evq);
            ck({tag, " ev_pool"}, ev_pool, pool);
        end
    endtask

    task automatic send(string tag, int vq, int dom, int dst);
        @(negedge clk);
        req_valid = 1; req_vq = vq[11:0]; req_dom = dom[3:0]; req_dst = dst[11:0];
        predict(vq, dom, dst);
        @(negedge clk);
        req_valid = 0;
        check_send(tag, vq, dom, dst);
    endtask

    task automatic mgmt(string tag, int pool, int op, int slot, int vq, int dom, int lo, int hi);
        @(negedge clk);
        drive_mgmt(pool, op, slot, vq, dom, lo, hi);
        model_apply(pool, op, slot, vq, dom, lo, hi);
        @(negedge clk);
        mgmt_valid = 0;
        check_ev(tag, pool);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        ck("R1 rsp_valid", rsp_valid, 0);
        ck("R1 div_valid", div_valid, 0);
        ck("R1 ev_valid", ev_valid, 0);
        ck("R1 req_ready", req_ready, 1);
        send("R1 R3 empty divert", 5, 2, 15);

        // R2, R5, R6
        mgmt("R2 install", 0, 0, 3, 5, 2, 10, 20);
        send("R2 grant", 5, 2, 15);
        send("R6 low edge", 5, 2, 10);
        send("R6 high edge", 5, 2, 20);
        send("R6 above range", 5, 2, 21);
        send("R6 below range", 5, 2, 9);
        send("R5 wrong domain", 5, 1, 15);

        // R11: receive pool
        mgmt("R11 rx install", 1, 0, 7, 15, 0, 0, 0);
        send("R11 dst local", 5, 2, 15);
        send("R11 dst remote", 5, 2, 16);
        send("R11 tx unaffected", 15, 2, 15);

        // R7: reinstall same name keeps slot
        mgmt("R7 replace", 0, 0, 9, 5, 1, 0, 3);
        send("R7 new attrs same slot", 5, 1, 2);

        // R9, R12: rebind slot to new name
        mgmt("R9 displace", 0, 0, 3, 6, 4, 0, 100);
        send("R12 old name diverts", 5, 1, 2);
        send("R12 new name hits", 6, 4, 50);

        // R8: evict
        mgmt("R8 evict tx", 0, 1, 3, 0, 0, 0, 0);
        send("R8 evicted diverts", 6, 4, 50);
        mgmt("R8 evict empty", 0, 1, 3, 0, 0, 0, 0);
        mgmt("R8 evict rx", 1, 1, 7, 0, 0, 0, 0);

        // R10: same-cycle write and lookup
        @(negedge clk);
        drive_mgmt(0, 0, 4, 8, 3, 0, 50);
        req_valid = 1; req_vq = 8; req_dom = 3; req_dst = 1;
        predict(8, 3, 1);
        model_apply(0, 0, 4, 8, 3, 0, 50);
        @(negedge clk);
        req_valid = 0; mgmt_valid = 0;
        check_send("R10 old mapping", 8, 3, 1);
        check_ev("R10 ev", 0);
        send("R10 new mapping next", 8, 3, 1);

        // R4: divert stall
        @(negedge clk);
        div_ready = 0;
        req_valid = 1; req_vq = 100; req_dom = 1; req_dst = 7;
        @(negedge clk);
        ck("R4 first divert", div_vq, 100);
        req_vq = 101; req_dst = 9;
        for (int k = 0; k < 3; k++) begin
            ck("R4 ready low", req_ready, 0);
            ck("R4 div stays", div_valid, 1);
            ck("R4 payload stable", div_vq, 100);
            ck("R4 no rsp", rsp_valid, 0);
            @(negedge clk);
        end
        div_ready = 1;
        @(negedge clk);
        req_valid = 0;
        ck("R4 held req taken", div_vq, 101);
        ck("R4 held req valid", div_valid, 1);
        ck("R4 held dst", div_dst, 9);
        @(negedge clk);
        ck("R4 drained", div_valid, 0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int r, vq, dom, dst, lo;
            r = $urandom_range(0, 9);
            vq = $urandom_range(0, 23);
            dom = $urandom_range(0, 3);
            if (r < 3) begin
                lo = $urandom_range(0, 20);
                mgmt("R7 R9 rand mgmt", $urandom_range(0, 1), (r == 0), $urandom_range(0, 15),
                     vq, dom, lo, lo + $urandom_range(0, 10));
            end else begin
                dst = $urandom_range(0, 30);
                send("R2 R5 R6 R12 rand send", vq, dom, dst);
            end
        end
        finish_run();
    end
endmodule